// File: doc/BRIEF.md
# Packed Single-Precision Compare and Min/Max Unit

This unit evaluates comparisons and selections over two 128-bit operands, each carrying four IEEE-754 single-precision lanes (lane 0 in bits 31:0). One opcode picks the operation: a predicate compare that writes a full-width lane mask, a scalar compare that sets six condition flags, or a lane-wise minimum or maximum. A scalar select restricts the mask and min/max operations to lane 0, and lanes 1 to 3 of the first operand then pass through unchanged.

A one-cycle `start` pulse samples the inputs. The result and the flags are registered on that edge, `valid` rises for the following cycle, and both outputs hold until the next pulse. Ordering uses sign-magnitude logic. Both zeros compare equal. A NaN is any value with an all-ones exponent and a nonzero mantissa, so infinities are ordered. The min/max choice always returns the second operand when the lanes are equal or unordered.

Top module: `pf32_cmp_minmax`

## Requirements
- R1: With opcode 2'b00, each lane of `res` is 32'hFFFF_FFFF when the predicate selected by `pred[2:0]` holds and 32'h0000_0000 when it does not. The codes are 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal and 7 ordered, and `pred[7:3]` is ignored.
- R2: With `scalar`=1 and opcode 2'b00, only lane 0 receives the mask, and `res[127:32]` equals `src_a[127:32]`.
- R3: A lane is NaN when its exponent bits 30:23 are all ones and its mantissa bits 22:0 are nonzero. Unordered (code 3) holds when either input lane is NaN, and ordered (code 7) holds only when neither is; an infinity is not NaN.
- R4: The not-equal, not-less-than and not-less-or-equal predicates (codes 4, 5, 6) are true when the inputs are unordered, and equal, less-than and less-or-equal (codes 0, 1, 2) are false.
- R5: With opcode 2'b01 (flag compare of lane 0), an unordered pair sets ZF, PF and CF to 1. The flag vector layout is bit 0 ZF, bit 1 PF, bit 2 CF, bit 3 OF, bit 4 AF, bit 5 SF, and `res` equals `src_a`.
- R6: For an ordered flag compare, ZF is 1 exactly when the lanes are equal, CF is 1 exactly when lane 0 of A is less than lane 0 of B, and PF is 0.
- R7: OF, AF and SF are always 0, and every opcode other than 2'b01 registers an all-zero flag vector.
- R8: Ordering is by sign and magnitude: +0 (32'h0000_0000) and -0 (32'h8000_0000) compare equal, and the more negative of two negative values is the lesser.
- R9: Opcodes 2'b10 (minimum) and 2'b11 (maximum) return the B lane when either lane is NaN or the two lanes compare equal, including +0 against -0. Otherwise they return the lesser or the greater lane.
- R10: With `scalar`=1, minimum and maximum write only lane 0, and lanes 1 to 3 come from `src_a`.
- R11: `res` and `flags` take the new values on the clock edge that samples `start`=1, and `valid` is 1 for exactly the cycle after each sampled start. The outputs hold while `start` is 0, and starts in consecutive cycles each produce a result.
- R12: While `rst` is high, `valid`, `res` and `flags` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Sample the operands and launch an operation |
| opcode | input | 2 | 00 mask compare, 01 flag compare, 10 minimum, 11 maximum |
| scalar | input | 1 | Restrict mask compare and min/max to lane 0 |
| pred | input | 8 | Predicate immediate; bits 2:0 are used |
| src_a | input | 128 | First operand, four float32 lanes |
| src_b | input | 128 | Second operand, four float32 lanes |
| res | output | 128 | Registered result |
| flags | output | 6 | Registered flags {SF,AF,OF,CF,PF,ZF} |
| valid | output | 1 | One-cycle strobe after each start |

## Verification
The embedded assertions watch several properties on every cycle. They check the start-to-valid timing and the holding of outputs between starts. They check that the upper flags are always clear and that PF never appears without ZF and CF. They also check that each mask lane is all ones or all zeros, that each min/max lane is one of its two inputs, and that the scalar forms pass the upper lanes through. Only the bench's scenarios show that the right value was chosen. These cover the predicate codes against NaN, infinity and signed-zero operands, the negative-number ordering, the preference for B on ties and NaNs, and the exact flag patterns of the scalar compare.

// File: rtl/pf32_pkg.sv
package pf32_pkg;

    localparam int EXP_W  = 8;
    localparam int MAN_W  = 23;
    localparam int LANE_W = 1 + EXP_W + MAN_W;
    localparam int LANES  = 4;
    localparam int PRED_W = 3;

    typedef enum logic [1:0] {
        OP_MASK  = 2'b00,
        OP_FLAGS = 2'b01,
        OP_MIN   = 2'b10,
        OP_MAX   = 2'b11
    } op_e;

    typedef enum logic [PRED_W-1:0] {
        PR_EQ    = 3'd0,
        PR_LT    = 3'd1,
        PR_LE    = 3'd2,
        PR_UNORD = 3'd3,
        PR_NEQ   = 3'd4,
        PR_NLT   = 3'd5,
        PR_NLE   = 3'd6,
        PR_ORD   = 3'd7
    } pred_e;

    // relation of one lane pair; eq and lt are never set when unord is set
    typedef struct packed {
        logic unord;
        logic eq;
        logic lt;
    } lane_rel_t;

    // packed MSB first, so zf lands on bit 0
    typedef struct packed {
        logic sf;
        logic af;
        logic of;
        logic cf;
        logic pf;
        logic zf;
    } flags_t;

    function automatic logic pred_hit(pred_e p, lane_rel_t r);
        logic h;
        case (p)
            PR_EQ:    h = r.eq;
            PR_LT:    h = r.lt;
            PR_LE:    h = r.lt | r.eq;
            PR_UNORD: h = r.unord;
            PR_NEQ:   h = ~r.eq;
            PR_NLT:   h = ~r.lt;
            PR_NLE:   h = ~(r.lt | r.eq);
            default:  h = ~r.unord;
        endcase
        return h;
    endfunction

endpackage

// File: rtl/pf32_lane_rel.sv
module pf32_lane_rel
    import pf32_pkg::*;
#(
    parameter int EW = EXP_W,
    parameter int MW = MAN_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EW+MW:0]    a,
    input  logic [EW+MW:0]    b,
    output lane_rel_t         rel
);
    localparam int W = 1 + EW + MW;

    logic          sign_a, sign_b;
    logic [W-2:0]  mag_a, mag_b;
    logic          nan_a, nan_b;
    logic          zeros;
    logic          same;
    logic          less;

    assign sign_a = a[W-1];
    assign sign_b = b[W-1];
    assign mag_a  = a[W-2:0];
    assign mag_b  = b[W-2:0];
    assign nan_a  = (&a[W-2 -: EW]) && (|a[MW-1:0]);
    assign nan_b  = (&b[W-2 -: EW]) && (|b[MW-1:0]);
    assign zeros  = (mag_a == '0) && (mag_b == '0);
    assign same   = (a == b) || zeros;

    always_comb begin
        case ({sign_a, sign_b})
            2'b00:   less = mag_a < mag_b;
            2'b11:   less = mag_a > mag_b;
            2'b10:   less = ~zeros;
            default: less = 1'b0;
        endcase
    end

    always_comb begin
        rel.unord = nan_a | nan_b;
        rel.eq    = ~(nan_a | nan_b) & same;
        rel.lt    = ~(nan_a | nan_b) & less;
    end

    // R8: equality and strict order are exclusive
    p_eq_lt_excl_r8: assert property (@(posedge clk) disable iff (rst)
        !(rel.eq && rel.lt));
    // R3: an unordered pair is neither equal nor less
    p_unord_clean_r3: assert property (@(posedge clk) disable iff (rst)
        rel.unord |-> (!rel.eq && !rel.lt));

endmodule

// File: rtl/pf32_lane_op.sv
module pf32_lane_op
    import pf32_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic          clk,
    input  logic          rst,
    input  op_e           op,
    input  pred_e         pred,
    input  lane_rel_t     rel,
    input  logic [W-1:0]  a,
    input  logic [W-1:0]  b,
    output logic [W-1:0]  y
);
    logic         hit;
    logic         tie_or_nan;
    logic [W-1:0] lo, hi;

    assign hit        = pred_hit(pred, rel);
    assign tie_or_nan = rel.unord | rel.eq;
    assign lo         = tie_or_nan ? b : (rel.lt ? a : b);
    assign hi         = tie_or_nan ? b : (rel.lt ? b : a);

    always_comb begin
        case (op)
            OP_MASK: y = {W{hit}};
            OP_MIN:  y = lo;
            OP_MAX:  y = hi;
            default: y = a;
        endcase
    end

    // R1: a mask lane is all ones or all zeros
    p_mask_full_r1: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MASK) |-> (y == '0 || y == '1));
    // R9: min/max never invents a value
    p_pick_input_r9: assert property (@(posedge clk) disable iff (rst)
        (op == OP_MIN || op == OP_MAX) |-> (y == a || y == b));
    // R9: unordered or tied lanes yield B
    p_tie_gives_b_r9: assert property (@(posedge clk) disable iff (rst)
        ((op == OP_MIN || op == OP_MAX) && (rel.unord || rel.eq)) |-> (y == b));

endmodule

// File: rtl/pf32_flag_gen.sv
module pf32_flag_gen
    import pf32_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  lane_rel_t rel,
    output flags_t    fl
);
    always_comb begin
        fl = '0;
        if (rel.unord) begin
            fl.zf = 1'b1;
            fl.pf = 1'b1;
            fl.cf = 1'b1;
        end else begin
            fl.zf = rel.eq;
            fl.cf = rel.lt;
        end
    end

    // R5: unordered raises the three flags together
    p_unord_flags_r5: assert property (@(posedge clk) disable iff (rst)
        rel.unord |-> (fl.zf && fl.pf && fl.cf));
    // R6: ordered never sets PF
    p_ord_no_pf_r6: assert property (@(posedge clk) disable iff (rst)
        !rel.unord |-> !fl.pf);

endmodule

// File: rtl/pf32_cmp_minmax.sv
module pf32_cmp_minmax
    import pf32_pkg::*;
#(
    parameter int N_LANES = LANES,
    parameter int EW      = EXP_W,
    parameter int MW      = MAN_W
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            start,
    input  logic [1:0]                      opcode,
    input  logic                            scalar,
    input  logic [7:0]                      pred,
    input  logic [N_LANES*(1+EW+MW)-1:0]    src_a,
    input  logic [N_LANES*(1+EW+MW)-1:0]    src_b,
    output logic [N_LANES*(1+EW+MW)-1:0]    res,
    output logic [5:0]                      flags,
    output logic                            valid
);
    localparam int W     = 1 + EW + MW;
    localparam int TOT_W = N_LANES * W;

    op_e                op;
    pred_e              pcode;
    lane_rel_t          rel   [N_LANES];
    logic [W-1:0]       lane_y[N_LANES];
    logic [TOT_W-1:0]   res_d;
    flags_t             fl_cmp;
    flags_t             fl_d;
    logic               keep_upper;

    logic [TOT_W-1:0]   res_q;
    flags_t             fl_q;
    logic               valid_q;

    assign op         = op_e'(opcode);
    assign pcode      = pred_e'(pred[PRED_W-1:0]);
    assign keep_upper = scalar && (op != OP_FLAGS);

    for (genvar i = 0; i < N_LANES; i++) begin : g_lane
        pf32_lane_rel #(.EW(EW), .MW(MW)) u_rel (
            .clk (clk),
            .rst (rst),
            .a   (src_a[i*W +: W]),
            .b   (src_b[i*W +: W]),
            .rel (rel[i])
        );

        pf32_lane_op #(.W(W)) u_op (
            .clk  (clk),
            .rst  (rst),
            .op   (op),
            .pred (pcode),
            .rel  (rel[i]),
            .a    (src_a[i*W +: W]),
            .b    (src_b[i*W +: W]),
            .y    (lane_y[i])
        );

        if (i == 0) begin : g_low
            assign res_d[W-1:0] = lane_y[0];
        end else begin : g_up
            assign res_d[i*W +: W] = keep_upper ? src_a[i*W +: W] : lane_y[i];
        end
    end

    pf32_flag_gen u_flags (
        .clk (clk),
        .rst (rst),
        .rel (rel[0]),
        .fl  (fl_cmp)
    );

    assign fl_d = (op == OP_FLAGS) ? fl_cmp : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q   <= '0;
            fl_q    <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= start;
            if (start) begin
                res_q <= res_d;
                fl_q  <= fl_d;
            end
        end
    end

    assign res   = res_q;
    assign flags = fl_q;
    assign valid = valid_q;

    // R11: strobe follows each sampled start
    p_valid_after_start_r11: assert property (@(posedge clk) disable iff (rst)
        start |=> valid);
    p_no_spurious_valid_r11: assert property (@(posedge clk) disable iff (rst)
        !start |=> !valid);
    // R11: outputs hold between starts
    p_hold_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !start |=> ($stable(res) && $stable(flags)));
    // R7: upper flags are never raised
    p_upper_flags_zero_r7: assert property (@(posedge clk) disable iff (rst)
        flags[5:3] == 3'b000);
    // R5: PF only ever appears with ZF and CF
    p_pf_implies_unord_r5: assert property (@(posedge clk) disable iff (rst)
        flags[1] |-> (flags[0] && flags[2]));
    // R2 / R10: scalar forms keep the upper lanes of A
    p_scalar_upper_r2: assert property (@(posedge clk) disable iff (rst)
        (start && scalar && opcode != 2'b01) |=> (res[TOT_W-1:W] == $past(src_a[TOT_W-1:W])));

endmodule

// File: tb/test_pf32_cmp_minmax.sv
`timescale 1ns/1ps
module test_pf32_cmp_minmax;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start = 1'b0;
    logic [1:0]   opcode = '0;
    logic         scalar = 1'b0;
    logic [7:0]   pred = '0;
    logic [127:0] src_a = '0;
    logic [127:0] src_b = '0;
    logic [127:0] res;
    logic [5:0]   flags;
    logic         valid;

    int checks = 0;
    int errors = 0;

    logic [127:0] q_res[$];
    logic [5:0]   q_fl[$];
    string        q_tag[$];
    logic [127:0] last_res;
    logic [5:0]   last_fl;

    always #2.5 clk = ~clk;

    pf32_cmp_minmax i_pf32_cmp_minmax (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .scalar(scalar),
        .pred(pred), .src_a(src_a), .src_b(src_b), .res(res), .flags(flags),
        .valid(valid)
    );

    localparam logic [31:0] ONE  = 32'h3F80_0000;
    localparam logic [31:0] TWO  = 32'h4000_0000;
    localparam logic [31:0] THR  = 32'h4040_0000;
    localparam logic [31:0] MONE = 32'hBF80_0000;
    localparam logic [31:0] MTWO = 32'hC000_0000;
    localparam logic [31:0] PZ   = 32'h0000_0000;
    localparam logic [31:0] NZ   = 32'h8000_0000;
    localparam logic [31:0] QNAN = 32'h7FC0_0000;
    localparam logic [31:0] SNAN = 32'h7F80_0001;
    localparam logic [31:0] PINF = 32'h7F80_0000;

    // monotone integer key: zeros collapse to one point
    function automatic logic [31:0] okey(logic [31:0] x);
        if (x[30:0] == 31'd0) return 32'h8000_0000;
        return x[31] ? ~x : (x | 32'h8000_0000);
    endfunction

    function automatic logic is_nan(logic [31:0] x);
        return (x[30:23] == 8'hFF) && (x[22:0] != 23'd0);
    endfunction

    function automatic logic m_hit(logic [2:0] p, logic [31:0] a, logic [31:0] b);
        logic n, e, l;
        n = is_nan(a) || is_nan(b);
        e = !n && (okey(a) == okey(b));
        l = !n && (okey(a) <  okey(b));
        case (p)
            3'd0: return e;
            3'd1: return l;
            3'd2: return e || l;
            3'd3: return n;
            3'd4: return !e;
            3'd5: return !l;
            3'd6: return !(e || l);
            default: return !n;
        endcase
    endfunction

    function automatic logic [31:0] m_mm(logic is_max, logic [31:0] a, logic [31:0] b);
        if (is_nan(a) || is_nan(b) || okey(a) == okey(b)) return b;
        if (is_max) return (okey(a) > okey(b)) ? a : b;
        return (okey(a) < okey(b)) ? a : b;
    endfunction

    task automatic issue(input logic [1:0] op, input logic sc, input logic [7:0] p,
                         input logic [127:0] a, input logic [127:0] b, input string tag);
        logic [127:0] er;
        logic [5:0]   ef;
        er = '0;
        ef = '0;
        for (int i = 0; i < 4; i++) begin
            logic [31:0] la, lb, ly;
            la = a[i*32 +: 32];
            lb = b[i*32 +: 32];
            case (op)
                2'b00:   ly = {32{m_hit(p[2:0], la, lb)}};
                2'b10:   ly = m_mm(1'b0, la, lb);
                2'b11:   ly = m_mm(1'b1, la, lb);
                default: ly = la;
            endcase
            if (sc && op != 2'b01 && i > 0) ly = la;
            er[i*32 +: 32] = ly;
        end
        if (op == 2'b01) begin
            if (is_nan(a[31:0]) || is_nan(b[31:0])) ef = 6'b000111;
            else ef = {3'b000, okey(a[31:0]) < okey(b[31:0]), 1'b0,
                       okey(a[31:0]) == okey(b[31:0])};
        end
        @(negedge clk);
        opcode = op; scalar = sc; pred = p; src_a = a; src_b = b; start = 1'b1;
        q_res.push_back(er);
        q_fl.push_back(ef);
        q_tag.push_back(tag);
        last_res = er;
        last_fl  = ef;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        start = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    // monitor: samples 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && valid) begin
                checks++;
                if (q_res.size() == 0) begin
                    errors++;
                    $display("FAIL R11 unexpected valid: actual res=%h expected no result", res);
                end else begin
                    logic [127:0] er;
                    logic [5:0]   ef;
                    string        tg;
                    er = q_res.pop_front();
                    ef = q_fl.pop_front();
                    tg = q_tag.pop_front();
                    if (res !== er || flags !== ef) begin
                        errors++;
                        $display("FAIL %s: actual res=%h flags=%b expected res=%h flags=%b",
                                 tg, res, flags, er, ef);
                    end
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [127:0] va, vb;
        repeat (3) @(negedge clk);
        checks++;
        if (valid !== 1'b0 || res !== '0 || flags !== '0) begin
            errors++;
            $display("FAIL R12 reset: actual v=%b res=%h fl=%b expected zeros", valid, res, flags);
        end
        @(negedge clk);
        rst = 1'b0;

        // packed mask compares, every predicate code (R1, R3, R4, R8)
        va = {QNAN, PZ, MTWO, ONE};
        vb = {ONE,  NZ, MONE, TWO};
        issue(2'b00, 1'b0, 8'h00, va, vb, "R1 eq");
        issue(2'b00, 1'b0, 8'hF9, va, vb, "R1 lt upper pred bits ignored");
        issue(2'b00, 1'b0, 8'h02, va, vb, "R8 le with signed zero");
        issue(2'b00, 1'b0, 8'h03, va, vb, "R3 unord");
        issue(2'b00, 1'b0, 8'h04, va, vb, "R4 neq");
        issue(2'b00, 1'b0, 8'h05, va, vb, "R4 nlt");
        issue(2'b00, 1'b0, 8'h06, va, vb, "R4 nle");
        issue(2'b00, 1'b0, 8'h07, va, vb, "R3 ord");
        issue(2'b00, 1'b0, 8'h07, {PINF, SNAN, PINF, MTWO}, {PINF, ONE, QNAN, MTWO},
              "R3 inf is ordered");
        issue(2'b00, 1'b0, 8'h01, {MTWO, MONE, NZ, PZ}, {MONE, MTWO, PZ, NZ},
              "R8 negative ordering");
        idle(2);
        // scalar mask (R2)
        issue(2'b00, 1'b1, 8'h01, {THR, TWO, QNAN, ONE}, {ONE, ONE, ONE, TWO}, "R2 scalar mask");
        issue(2'b00, 1'b1, 8'h00, {THR, TWO, QNAN, ONE}, {ONE, ONE, ONE, TWO}, "R2 scalar false");
        idle(2);
        // flag compares (R5, R6, R7)
        issue(2'b01, 1'b0, 8'h00, {TWO, TWO, TWO, ONE},  {ONE, ONE, ONE, TWO}, "R6 flags less");
        issue(2'b01, 1'b0, 8'h00, {TWO, TWO, TWO, TWO},  {ONE, ONE, ONE, TWO}, "R6 flags equal");
        issue(2'b01, 1'b0, 8'h00, {TWO, TWO, TWO, NZ},   {ONE, ONE, ONE, PZ},  "R6 flags signed zero");
        issue(2'b01, 1'b0, 8'h00, {TWO, TWO, TWO, THR},  {ONE, ONE, ONE, MONE}, "R6 flags greater");
        issue(2'b01, 1'b0, 8'h00, {TWO, TWO, TWO, QNAN}, {ONE, ONE, ONE, ONE}, "R5 flags nan");
        issue(2'b01, 1'b1, 8'h00, {TWO, TWO, TWO, PINF}, {ONE, ONE, ONE, SNAN}, "R5 flags snan");
        issue(2'b00, 1'b0, 8'h03, {TWO, TWO, TWO, QNAN}, {ONE, ONE, ONE, ONE}, "R7 flags cleared");
        idle(2);
        // min / max (R9, R10)
        va = {MTWO, QNAN, NZ, ONE};
        vb = {MONE, ONE,  PZ, TWO};
        issue(2'b10, 1'b0, 8'h00, va, vb, "R9 min");
        issue(2'b11, 1'b0, 8'h00, va, vb, "R9 max");
        issue(2'b10, 1'b0, 8'h00, vb, va, "R9 min swapped");
        issue(2'b11, 1'b0, 8'h00, vb, va, "R9 max swapped");
        issue(2'b10, 1'b1, 8'h00, {THR, THR, THR, TWO}, {ONE, ONE, ONE, ONE}, "R10 scalar min");
        issue(2'b11, 1'b1, 8'h00, {ONE, ONE, ONE, ONE}, {THR, THR, THR, TWO}, "R10 scalar max");
        idle(4);

        // hold between starts (R11)
        checks++;
        if (res !== last_res || flags !== last_fl || valid !== 1'b0) begin
            errors++;
            $display("FAIL R11 hold: actual res=%h fl=%b v=%b expected res=%h fl=%b v=0",
                     res, flags, valid, last_res, last_fl);
        end
        checks++;
        if (q_res.size() != 0) begin
            errors++;
            $display("FAIL R11 missing results: actual pending=%0d expected 0", q_res.size());
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule